// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block watches the byte stream on an 8-bit NAND flash data port and builds Hamming-style parity on the fly. A 512-byte page is handled as two 256-byte segments, each with its own parity set: a 16-bit line-parity word derived from the byte's position within the segment, and a 6-bit column-parity field derived from the bit positions inside each byte. Software compares these values against the ECC stored in the spare area and performs any correction itself.

A clear input empties both parity sets, the byte counter and the readout pointer. An enable input gates accumulation, so the spare and stored-ECC bytes that follow the data area can be read through the same port without changing the result. Results are read as 16-bit words: line word, then column word, for the first segment, and then the same pair for the second segment. Reading a column word moves the readout on to the next segment.

Top module: `nand_ecc_gen`

## Requirements
- R1: A cycle with `clr_i` high empties both parity sets, the byte counter and the readout pointer on that clock edge. A byte strobed in the same cycle is dropped.
- R2: A byte is folded in only on a clock edge where `byte_vld_i` and `en_i` are both high and `clr_i` is low. On every other edge the parity, the counter and hence every output word stay unchanged. A folded byte is visible on `rd_data_o` from the following cycle on.
- R3: Line parity: for the byte address a (0..255) within the segment and each address bit k (0..7), the XOR of all the bits of the byte is accumulated into line bit 2k+1 when bit k of a is 1, and into line bit 2k when bit k of a is 0.
- R4: Column parity, with d the data byte: CP5 = ^d[7:4], CP4 = ^d[3:0], CP3 = ^{d7,d6,d3,d2}, CP2 = ^{d5,d4,d1,d0}, CP1 = ^{d7,d5,d3,d1} and CP0 = ^{d6,d4,d2,d0}. Each is accumulated by XOR over the segment.
- R5: Accumulated bytes 0..255 after a clear update segment set 1 only, and bytes 256..511 update set 2 only. Only folded bytes advance the counter. The 513th folded byte wraps to set 1 at address 0.
- R6: With `rd_sel_i` = 0, `rd_data_o` shows the 16-bit line word of the segment chosen by the readout pointer. Bit n of the word is line bit n.
- R7: With `rd_sel_i` = 1, `rd_data_o` shows the column word of that segment: 0xFF in bits 15:8, CP5..CP0 in bits 7:2, and 1 in bits 1:0.
- R8: A cycle with `rd_i` = 1 and `rd_sel_i` = 1 advances the readout pointer from segment 1 to segment 2, or from segment 2 back to segment 1. A line-word read (`rd_i` = 1 with `rd_sel_i` = 0) leaves the pointer where it is.
- R9: After reset, the line word reads 0x0000 and the column word reads 0xFF03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_i | input | 1 | Clears both parity sets, the counter and the readout pointer |
| en_i | input | 1 | Accumulation enable |
| byte_vld_i | input | 1 | One-cycle strobe that marks a byte on the data port |
| byte_i | input | 8 | Data byte |
| rd_i | input | 1 | Read strobe; on a column-word read it advances the readout pointer |
| rd_sel_i | input | 1 | Word select: 0 for the line word, 1 for the column word |
| rd_data_o | output | 16 | Selected parity word of the current segment |

## Verification
The assertions assume that `clr_i`, `en_i`, `byte_vld_i`, `rd_i` and `rd_sel_i` are synchronous to `clk` and remain stable across each rising edge. They also assume that the column-word frame in R7 can be checked whenever `rd_sel_i` is high. The bench changes every input on the falling edge and reads `rd_data_o` a short time after setting `rd_sel_i`. A read is therefore always taken from settled state, before the next rising edge can act on the read strobe.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Width of one readout word
  localparam int RD_W = 16;

  typedef enum logic {
    RD_LINE = 1'b0,
    RD_COL  = 1'b1
  } rd_sel_e;

endpackage

// File: rtl/nand_ecc_colpar.sv
// Combinational per-byte parity terms: the whole-byte parity and the split-half column terms.
module nand_ecc_colpar #(
  parameter int DATA_W = 8,
  localparam int SPLITS = $clog2(DATA_W),
  localparam int CP_W   = 2 * SPLITS
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              bpar_o,
  output logic [CP_W-1:0]   cterm_o
);

  always_comb begin
    bpar_o = ^data_i;
  end

  // For split s, the upper term covers bits whose index has bit s set.
  for (genvar s = 0; s < SPLITS; s++) begin : g_split
    logic hi_acc;
    logic lo_acc;
    always_comb begin
      hi_acc = 1'b0;
      lo_acc = 1'b0;
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> s) & 1) == 1) hi_acc = hi_acc ^ data_i[b];
        else                     lo_acc = lo_acc ^ data_i[b];
      end
    end
    assign cterm_o[2*s+1] = hi_acc;
    assign cterm_o[2*s]   = lo_acc;
  end

endmodule

// File: rtl/nand_ecc_acc.sv
// One segment's parity accumulator.
module nand_ecc_acc #(
  parameter int ADDR_W = 8,
  parameter int CP_W   = 6,
  localparam int LP_W  = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bpar_i,
  input  logic [CP_W-1:0]   cterm_i,
  output logic [LP_W-1:0]   lp_o,
  output logic [CP_W-1:0]   cp_o
);

  logic [LP_W-1:0] lp_q, lp_d;
  logic [CP_W-1:0] cp_q, cp_d;
  logic [LP_W-1:0] lp_flip;
  logic            ld_en;

  always_comb begin
    for (int k = 0; k < ADDR_W; k++) begin
      lp_flip[2*k+1] = bpar_i & addr_i[k];
      lp_flip[2*k]   = bpar_i & ~addr_i[k];
    end
  end

  always_comb begin
    ld_en = clr_i | upd_i;
    if (clr_i) begin
      lp_d = '0;
      cp_d = '0;
    end else begin
      lp_d = lp_q ^ lp_flip;
      cp_d = cp_q ^ cterm_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (ld_en) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;

endmodule

// File: rtl/nand_ecc_rdport.sv
// Readout pointer and word multiplexer.
module nand_ecc_rdport
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SEG = 2,
  parameter int LP_W    = 16,
  parameter int CP_W    = 6,
  localparam int PTR_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int PAD_W  = RD_W - CP_W - 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           rd_i,
  input  logic                           rd_sel_i,
  input  logic [NUM_SEG-1:0][LP_W-1:0]   lp_i,
  input  logic [NUM_SEG-1:0][CP_W-1:0]   cp_i,
  output logic [PTR_W-1:0]               ptr_o,
  output logic [RD_W-1:0]                rd_data_o
);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  rd_sel_e          sel;

  always_comb begin
    sel    = rd_sel_e'(rd_sel_i);
    ptr_en = clr_i | (rd_i & (sel == RD_COL));
    if (clr_i)                                ptr_d = '0;
    else if (ptr_q == PTR_W'(NUM_SEG - 1))    ptr_d = '0;
    else                                      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_comb begin
    if (sel == RD_COL) rd_data_o = {{PAD_W{1'b1}}, cp_i[ptr_q], 2'b11};
    else               rd_data_o = RD_W'(lp_i[ptr_q]);
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/nand_ecc_gen.sv
// Top: reset release, byte counter, per-segment accumulators and the readout port.
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SEG_BYTES = 256,
  parameter int NUM_SEG   = 2,
  localparam int ADDR_W   = $clog2(SEG_BYTES),
  localparam int LP_W     = 2 * ADDR_W,
  localparam int CP_W     = 2 * $clog2(DATA_W),
  localparam int CNT_W    = $clog2(SEG_BYTES * NUM_SEG),
  localparam int SIDX_W   = (CNT_W > ADDR_W) ? CNT_W - ADDR_W : 1,
  localparam int PTR_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd_i,
  input  logic              rd_sel_i,
  output logic [RD_W-1:0]   rd_data_o
);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Byte counter
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              acc_go;
  logic [SIDX_W-1:0] seg_idx;

  always_comb begin
    acc_go = byte_vld_i & en_i & ~clr_i;
    cnt_en = clr_i | acc_go;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  if (NUM_SEG > 1) begin : g_multi
    assign seg_idx = cnt_q[CNT_W-1:ADDR_W];
  end else begin : g_single
    assign seg_idx = '0;
  end

  // Per-byte parity terms
  logic            bpar;
  logic [CP_W-1:0] cterm;

  nand_ecc_colpar #(.DATA_W(DATA_W)) u_colpar (
    .data_i  (byte_i),
    .bpar_o  (bpar),
    .cterm_o (cterm)
  );

  // Segment accumulators
  logic [NUM_SEG-1:0][LP_W-1:0] lp_all;
  logic [NUM_SEG-1:0][CP_W-1:0] cp_all;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic upd;
    assign upd = acc_go & (seg_idx == SIDX_W'(g));
    nand_ecc_acc #(.ADDR_W(ADDR_W), .CP_W(CP_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr_i   (clr_i),
      .upd_i   (upd),
      .addr_i  (cnt_q[ADDR_W-1:0]),
      .bpar_i  (bpar),
      .cterm_i (cterm),
      .lp_o    (lp_all[g]),
      .cp_o    (cp_all[g])
    );
  end

  // Readout
  logic [PTR_W-1:0] rd_ptr;

  nand_ecc_rdport #(.NUM_SEG(NUM_SEG), .LP_W(LP_W), .CP_W(CP_W)) u_rdport (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (clr_i),
    .rd_i      (rd_i),
    .rd_sel_i  (rd_sel_i),
    .lp_i      (lp_all),
    .cp_i      (cp_all),
    .ptr_o     (rd_ptr),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int NUM_SEG = 2,
  parameter int LP_W    = 16,
  parameter int CP_W    = 6,
  parameter int CNT_W   = 9,
  parameter int PTR_W   = 1
) (
  input logic                         clk,
  input logic                         rst_sync_n,
  input logic                         clr_i,
  input logic                         en_i,
  input logic                         byte_vld_i,
  input logic                         rd_i,
  input logic                         rd_sel_i,
  input logic [15:0]                  rd_data_o,
  input logic [NUM_SEG-1:0][LP_W-1:0] lp_all,
  input logic [NUM_SEG-1:0][CP_W-1:0] cp_all,
  input logic [CNT_W-1:0]             cnt_q,
  input logic [PTR_W-1:0]             rd_ptr
);

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_i |=> (lp_all == '0 && cp_all == '0 && cnt_q == '0 && rd_ptr == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_i && !(en_i && byte_vld_i)) |=> ($stable(lp_all) && $stable(cp_all) && $stable(cnt_q))); // R2

  AST_PAIR_LINK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lp_all[0][1] ^ lp_all[0][0]) == (cp_all[0][1] ^ cp_all[0][0])); // R3

  AST_SEG_ISOLATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_i && en_i && byte_vld_i && !cnt_q[CNT_W-1]) |=> ($stable(lp_all[NUM_SEG-1]) && $stable(cp_all[NUM_SEG-1]))); // R5

  AST_COL_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_sel_i |-> (rd_data_o[15:8] == 8'hFF && rd_data_o[1:0] == 2'b11)); // R7

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_i && rd_i && rd_sel_i) |=> (rd_ptr != $past(rd_ptr))); // R8

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_i && !(rd_i && rd_sel_i)) |=> $stable(rd_ptr)); // R8

endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(
  .NUM_SEG(NUM_SEG), .LP_W(LP_W), .CP_W(CP_W), .CNT_W(CNT_W), .PTR_W(PTR_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clr_i      (clr_i),
  .en_i       (en_i),
  .byte_vld_i (byte_vld_i),
  .rd_i       (rd_i),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .lp_all     (lp_all),
  .cp_all     (cp_all),
  .cnt_q      (cnt_q),
  .rd_ptr     (rd_ptr)
);

// File: tb/nand_ecc_gen_bench.sv
module nand_ecc_gen_bench;

  logic        clk;
  logic        rst_n;
  logic        clr_i;
  logic        en_i;
  logic        byte_vld_i;
  logic [7:0]  byte_i;
  logic        rd_i;
  logic        rd_sel_i;
  logic [15:0] rd_data_o;

  int n_chk;
  int n_fail;

  // Reference state
  logic [15:0] ref_lp [2];
  logic [5:0]  ref_cp [2];
  int          ref_cnt;

  nand_ecc_gen u_nand_ecc_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .en_i       (en_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rd_i       (rd_i),
    .rd_sel_i   (rd_sel_i),
    .rd_data_o  (rd_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ref_clear();
    ref_lp[0] = '0; ref_lp[1] = '0;
    ref_cp[0] = '0; ref_cp[1] = '0;
    ref_cnt   = 0;
  endtask

  task automatic ref_fold(input logic [7:0] b);
    int   idx  = ref_cnt % 512;
    int   seg  = idx / 256;
    int   addr = idx % 256;
    logic p    = 1'b0;
    for (int i = 0; i < 8; i++) p ^= b[i];
    for (int k = 0; k < 8; k++) begin
      if (((addr >> k) & 1) == 1) ref_lp[seg][2*k+1] ^= p;
      else                        ref_lp[seg][2*k]   ^= p;
    end
    ref_cp[seg] ^= {^(b & 8'hF0), ^(b & 8'h0F), ^(b & 8'hCC),
                    ^(b & 8'h33), ^(b & 8'hAA), ^(b & 8'h55)};
    ref_cnt++;
  endtask

  // One byte strobe; en selects whether it should be folded
  task automatic send(input logic [7:0] b, input logic en);
    byte_i = b; byte_vld_i = 1'b1; en_i = en;
    @(negedge clk);
    byte_vld_i = 1'b0;
    if (en) ref_fold(b);
  endtask

  task automatic do_clear(input logic with_byte);
    clr_i = 1'b1; en_i = 1'b1; byte_vld_i = with_byte; byte_i = 8'h5A;
    @(negedge clk);
    clr_i = 1'b0; byte_vld_i = 1'b0;
    ref_clear();
  endtask

  task automatic rd_pulse(input logic sel);
    rd_sel_i = sel; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  // Full readout sequence against the reference, then checks the wrap
  task automatic read_all(input string tag);
    for (int s = 0; s < 2; s++) begin
      rd_sel_i = 1'b0; #1;
      check({tag, " R6 line word"}, rd_data_o, ref_lp[s]);
      rd_sel_i = 1'b1; #1;
      check({tag, " R7 col word"}, rd_data_o, {8'hFF, ref_cp[s], 2'b11});
      @(negedge clk);
      rd_pulse(1'b1);
    end
    rd_sel_i = 1'b0; #1;
    check({tag, " R8 wrap to seg1"}, rd_data_o, ref_lp[0]);
  endtask

  task automatic t_reset();
    rd_sel_i = 1'b0; #1;
    check("R9 reset line", rd_data_o, 16'h0000);
    rd_sel_i = 1'b1; #1;
    check("R9 reset col", rd_data_o, 16'hFF03);
    @(negedge clk);
  endtask

  task automatic t_single();
    send(8'hE7, 1'b1);
    do_clear(1'b1);
    rd_sel_i = 1'b0; #1;
    check("R1 clear drops same-cycle byte", rd_data_o, 16'h0000);
    @(negedge clk);
    send(8'h01, 1'b1);
    rd_sel_i = 1'b0; #1;
    check("R3 single byte line", rd_data_o, 16'h5555);
    rd_sel_i = 1'b1; #1;
    check("R4 single byte col", rd_data_o, 16'hFF57);
    @(negedge clk);
    // line read must not move the pointer
    rd_pulse(1'b0);
    rd_sel_i = 1'b0; #1;
    check("R8 line read keeps pointer", rd_data_o, 16'h5555);
    @(negedge clk);
    // strobe without enable, enable without strobe
    send(8'h80, 1'b0);
    en_i = 1'b1; byte_i = 8'hFE; @(negedge clk);
    rd_sel_i = 1'b1; #1;
    check("R2 disabled bytes ignored", rd_data_o, 16'hFF57);
    @(negedge clk);
  endtask

  // kind: 0 all zero, 1 all ones, 2 random
  task automatic t_page(input int kind, input string tag);
    logic [7:0] b;
    do_clear(1'b0);
    for (int i = 0; i < 512; i++) begin
      b = (kind == 0) ? 8'h00 : (kind == 1) ? 8'hFF : 8'($urandom);
      send(b, 1'b1);
      if (kind == 2 && ($urandom % 8) == 0) begin
        en_i = 1'b1; @(negedge clk);
      end
    end
    for (int i = 0; i < 16; i++) send(8'($urandom), 1'b0);
    read_all({tag, " R2 R5"});
  endtask

  task automatic t_wrap();
    t_page(2, "wrap-base");
    send(8'h3C, 1'b1);
    send(8'h01, 1'b1);
    read_all("R5 wrap");
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; clr_i = 1'b0; en_i = 1'b0; byte_vld_i = 1'b0;
    byte_i = '0; rd_i = 1'b0; rd_sel_i = 1'b0;
    ref_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_page(0, "zero page");
    t_page(1, "ones page");
    t_page(2, "random page A");
    t_page(2, "random page B");
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule